// File: doc/BRIEF.md
# Cross-Domain Register Write Tracker

This block sits between a fast bus-side register port and a group of registers clocked by a slow, independent clock. When the bus writes one of those registers, the block captures the address and data and holds them. It then passes a request across to the slow clock with a toggle handshake. After the slow side has used the data, it sends an acknowledgement back the same way.

A write-complete flag, `wr_done`, goes low in the bus cycle after the write is accepted. It rises again only when the acknowledgement has reached the bus clock. Bus-side logic polls the flag before it issues the next write or read to the slow registers. An access that arrives while the flag is low is refused, and it can raise a sticky error flag. Addresses outside the slow window skip the handshake completely.

The slow window is the address range `AFF_LO`..`AFF_HI`, and both bounds are included. The synchronizer depth sets the round-trip latency. When the parameter `ERR_EN` is 0, the error flag is not built.

Top module: `xdw_write_tracker`

## Requirements
- R1: While reset is asserted and after reset is released, `wr_done` is 1, `acc_err` is 0 and `slow_we` is 0.
- R2: A write to an address inside the window while `wr_done` is 1 makes `wr_done` 0 after the next bus edge. `wr_done` stays 0 until the slow side acknowledges, which happens on the (SYNC_STAGES+1)-th slow edge after that bus edge. `wr_done` then returns to 1 on the SYNC_STAGES-th bus edge after the acknowledgement.
- R3: `slow_addr` and `slow_wdata` carry the address and data of the last accepted window write. They do not change while `wr_done` is 0.
- R4: Each accepted window write produces exactly one `slow_we` pulse, one slow cycle long. The pulse starts on the SYNC_STAGES-th slow edge after the write.
- R5: A read inside the window gives `rd_ok`=1 in the same cycle if `wr_done` is 1, and `rd_ok`=0 if `wr_done` is 0.
- R6: A window write while `wr_done` is 0 is dropped. It produces no `slow_we` pulse and changes neither `slow_addr` nor `slow_wdata`.
- R7: With `ERR_EN`=1, a window write or read while `wr_done` is 0 sets `acc_err` after the next bus edge. The flag then stays at 1 until reset.
- R8: A write outside the window raises `byp_wr` in the same cycle and does not change `wr_done`. A read outside the window always gives `rd_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side asynchronous reset, active low |
| slow_clk | input | 1 | Slow register-domain clock |
| slow_rst_n | input | 1 | Slow-side asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe from the bus decoder |
| bus_rd_en | input | 1 | Read strobe from the bus decoder |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| wr_done | output | 1 | Write-complete flag; 1 means the next window access is safe |
| rd_ok | output | 1 | Read may be performed this cycle |
| byp_wr | output | 1 | Write outside the window, passed straight through |
| acc_err | output | 1 | Sticky flag for an access made too early |
| slow_we | output | 1 | One-cycle write strobe in the slow domain |
| slow_addr | output | AW | Held address for the slow domain |
| slow_wdata | output | DW | Held data for the slow domain |

## Verification
The bench sends a second window write in the cycle right after an accepted one. If the design forwarded it, a second `slow_we` pulse would appear, or the held data would change while the transfer is still in flight.

Window reads and writes are issued while a transfer is in flight and again after it completes. If the design gated `rd_ok` on the wrong flag, or let the error flag clear itself, the result would differ from the model in one of those two cases.

The bench also probes both edges of the address window with bypass accesses issued during a transfer. An off-by-one in the range decode would then either stall a bypass write or let it through the handshake.

The bench predicts `wr_done` to the exact bus cycle by counting slow and bus edges. A synchronizer chain one stage too long or too short would therefore raise the flag one cycle early or one cycle late.

// File: rtl/xdw_pkg.sv
package xdw_pkg;

   // Classification of one bus access.
   typedef enum logic [1:0] {
      ACC_IDLE   = 2'd0,
      ACC_SAFE   = 2'd1,
      ACC_EARLY  = 2'd2,
      ACC_BYPASS = 2'd3
   } acc_kind_e;

   // True when the window bounds fit inside an AW-bit address space.
   function automatic bit window_ok(input int lo, input int hi, input int aw);
      return (aw > 0) && (aw < 31) && (lo >= 0) && (lo <= hi) && (hi < (1 << aw));
   endfunction

endpackage

// File: rtl/xdw_sync.sv
module xdw_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0][W-1:0] chain;

   initial begin : g_param_chk
      if (STAGES < 2) $fatal(1, "xdw_sync: STAGES must be at least 2");
      if (W < 1)      $fatal(1, "xdw_sync: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[LAST-1:0], d};
   end

   assign q = chain[LAST];

endmodule

// File: rtl/xdw_bus_port.sv
module xdw_bus_port
   import xdw_pkg::*;
#(
   parameter int AW     = 4,
   parameter int DW     = 8,
   parameter int AFF_LO = 4,
   parameter int AFF_HI = 11,
   parameter bit ERR_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          ack_seen,
   output logic          req_tgl,
   output logic [AW-1:0] hold_addr,
   output logic [DW-1:0] hold_data,
   output logic          wr_done,
   output logic          rd_ok,
   output logic          byp_wr,
   output logic          acc_err
);

   localparam logic [AW-1:0] WIN_LO = AW'(AFF_LO);
   localparam logic [AW-1:0] WIN_HI = AW'(AFF_HI);

   logic      in_win;
   logic      take;
   logic      req_q;
   acc_kind_e kind;

   assign in_win  = (addr >= WIN_LO) && (addr <= WIN_HI);
   assign wr_done = (req_q == ack_seen);

   always_comb begin
      kind = ACC_IDLE;
      if (wr_en || rd_en) begin
         if (!in_win)      kind = ACC_BYPASS;
         else if (wr_done) kind = ACC_SAFE;
         else              kind = ACC_EARLY;
      end
   end

   assign take   = wr_en && (kind == ACC_SAFE);
   assign rd_ok  = rd_en && ((kind == ACC_SAFE) || (kind == ACC_BYPASS));
   assign byp_wr = wr_en && (kind == ACC_BYPASS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q     <= 1'b0;
         hold_addr <= '0;
         hold_data <= '0;
      end else if (take) begin
         req_q     <= ~req_q;
         hold_addr <= addr;
         hold_data <= wdata;
      end
   end

   assign req_tgl = req_q;

   generate
      if (ERR_EN) begin : g_err
         logic err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  err_q <= 1'b0;
            else if (kind == ACC_EARLY)  err_q <= 1'b1;
         end
         assign acc_err = err_q;
      end else begin : g_no_err
         assign acc_err = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/xdw_slow_port.sv
module xdw_slow_port #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_tgl,
   output logic ack_tgl,
   output logic strobe
);

   logic req_seen;
   logic ack_q;

   xdw_sync #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_tgl),
      .q     (req_seen)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= req_seen;
   end

   assign strobe  = req_seen ^ ack_q;
   assign ack_tgl = ack_q;

endmodule

// File: rtl/xdw_write_tracker.sv
module xdw_write_tracker
   import xdw_pkg::*;
#(
   parameter int AW          = 4,
   parameter int DW          = 8,
   parameter int AFF_LO      = 4,
   parameter int AFF_HI      = 11,
   parameter int SYNC_STAGES = 2,
   parameter bit ERR_EN      = 1'b1
) (
   input  logic          bus_clk,
   input  logic          bus_rst_n,
   input  logic          slow_clk,
   input  logic          slow_rst_n,
   input  logic          bus_wr_en,
   input  logic          bus_rd_en,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic          wr_done,
   output logic          rd_ok,
   output logic          byp_wr,
   output logic          acc_err,
   output logic          slow_we,
   output logic [AW-1:0] slow_addr,
   output logic [DW-1:0] slow_wdata
);

   initial begin : g_param_chk
      if (!window_ok(AFF_LO, AFF_HI, AW)) $fatal(1, "xdw_write_tracker: bad address window");
      if (DW < 1)                         $fatal(1, "xdw_write_tracker: DW must be positive");
      if (SYNC_STAGES < 2)                $fatal(1, "xdw_write_tracker: SYNC_STAGES below 2");
   end

   logic req_tgl;
   logic ack_tgl;
   logic ack_seen;

   xdw_bus_port #(
      .AW(AW), .DW(DW), .AFF_LO(AFF_LO), .AFF_HI(AFF_HI), .ERR_EN(ERR_EN)
   ) u_bus (
      .clk       (bus_clk),
      .rst_n     (bus_rst_n),
      .wr_en     (bus_wr_en),
      .rd_en     (bus_rd_en),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .ack_seen  (ack_seen),
      .req_tgl   (req_tgl),
      .hold_addr (slow_addr),
      .hold_data (slow_wdata),
      .wr_done   (wr_done),
      .rd_ok     (rd_ok),
      .byp_wr    (byp_wr),
      .acc_err   (acc_err)
   );

   xdw_slow_port #(.SYNC_STAGES(SYNC_STAGES)) u_slow (
      .clk     (slow_clk),
      .rst_n   (slow_rst_n),
      .req_tgl (req_tgl),
      .ack_tgl (ack_tgl),
      .strobe  (slow_we)
   );

   xdw_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
      .clk   (bus_clk),
      .rst_n (bus_rst_n),
      .d     (ack_tgl),
      .q     (ack_seen)
   );

endmodule

// File: rtl/xdw_write_tracker_chk.sv
module xdw_write_tracker_chk #(
   parameter int AW     = 4,
   parameter int DW     = 8,
   parameter int AFF_LO = 4,
   parameter int AFF_HI = 11,
   parameter bit ERR_EN = 1'b1
) (
   input logic          bus_clk,
   input logic          bus_rst_n,
   input logic          slow_clk,
   input logic          slow_rst_n,
   input logic          bus_wr_en,
   input logic          bus_rd_en,
   input logic [AW-1:0] bus_addr,
   input logic          wr_done,
   input logic          rd_ok,
   input logic          acc_err,
   input logic          slow_we,
   input logic [AW-1:0] slow_addr,
   input logic [DW-1:0] slow_wdata
);

   logic hit;
   assign hit = (bus_addr >= AW'(AFF_LO)) && (bus_addr <= AW'(AFF_HI));

   AST_DONE_DROP: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (bus_wr_en && hit && wr_done) |=> !wr_done);                       // R2

   AST_HOLD_STABLE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      !wr_done |=> ($stable(slow_addr) && $stable(slow_wdata)));         // R3

   AST_STROBE_ONE: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
      slow_we |=> !slow_we);                                              // R4

   AST_RD_BLOCK: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (bus_rd_en && hit && !wr_done) |-> !rd_ok);                         // R5

   AST_EARLY_DROP: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (bus_wr_en && hit && !wr_done) |=> $stable(slow_wdata));            // R6

   AST_ERR_STICKY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      acc_err |=> acc_err);                                               // R7

   AST_ERR_SET: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (ERR_EN && (bus_wr_en || bus_rd_en) && hit && !wr_done) |=> acc_err); // R7

   AST_BYP_KEEP: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (bus_wr_en && !hit && wr_done) |=> wr_done);                        // R8

endmodule

bind xdw_write_tracker xdw_write_tracker_chk #(
   .AW(AW), .DW(DW), .AFF_LO(AFF_LO), .AFF_HI(AFF_HI), .ERR_EN(ERR_EN)
) chk_i (
   .bus_clk    (bus_clk),
   .bus_rst_n  (bus_rst_n),
   .slow_clk   (slow_clk),
   .slow_rst_n (slow_rst_n),
   .bus_wr_en  (bus_wr_en),
   .bus_rd_en  (bus_rd_en),
   .bus_addr   (bus_addr),
   .wr_done    (wr_done),
   .rd_ok      (rd_ok),
   .acc_err    (acc_err),
   .slow_we    (slow_we),
   .slow_addr  (slow_addr),
   .slow_wdata (slow_wdata)
);

// File: tb/xdw_write_tracker_tb_top.sv
module xdw_write_tracker_tb_top;

   localparam int AW   = 4;
   localparam int DW   = 8;
   localparam int LO   = 4;
   localparam int HI   = 11;
   localparam int SYNC = 2;

   logic bus_clk = 1'b0;
   logic slow_clk = 1'b0;
   logic rst_n = 1'b1;
   logic wr_en = 1'b0;
   logic rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic wr_done, rd_ok, byp_wr, acc_err, slow_we;
   logic [AW-1:0] slow_addr;
   logic [DW-1:0] slow_wdata;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // Reference model state
   bit m_done = 1'b1;
   bit m_err = 1'b0;
   int slow_cnt = 0;
   int bus_cnt = 0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_data = '0;

   always #10 bus_clk = ~bus_clk;                // 50 MHz
   initial begin #3; forever #80 slow_clk = ~slow_clk; end

   xdw_write_tracker #(
      .AW(AW), .DW(DW), .AFF_LO(LO), .AFF_HI(HI), .SYNC_STAGES(SYNC), .ERR_EN(1'b1)
   ) dut_i (
      .bus_clk(bus_clk), .bus_rst_n(rst_n), .slow_clk(slow_clk), .slow_rst_n(rst_n),
      .bus_wr_en(wr_en), .bus_rd_en(rd_en), .bus_addr(addr), .bus_wdata(wdata),
      .wr_done(wr_done), .rd_ok(rd_ok), .byp_wr(byp_wr), .acc_err(acc_err),
      .slow_we(slow_we), .slow_addr(slow_addr), .slow_wdata(slow_wdata)
   );

   function automatic bit in_win(input logic [AW-1:0] a);
      return (int'(a) >= LO) && (int'(a) <= HI);
   endfunction

   // Bus-side model
   always @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
         m_done = 1'b1; m_err = 1'b0; bus_cnt = 0; m_addr = '0; m_data = '0;
      end else begin
         bit was_done;
         was_done = m_done;
         if ((wr_en || rd_en) && in_win(addr)) begin
            if (!was_done) m_err = 1'b1;
            else if (wr_en) begin
               m_done = 1'b0; slow_cnt = SYNC + 1; m_addr = addr; m_data = wdata;
            end
         end
         if (bus_cnt > 0) begin
            bus_cnt--;
            if (bus_cnt == 0) m_done = 1'b1;
         end
      end
   end

   // Slow-side model
   always @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) slow_cnt = 0;
      else if (slow_cnt > 0) begin
         slow_cnt--;
         if (slow_cnt == 0) bus_cnt = SYNC;
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Compare every cycle, mid-way between a negedge and the next posedge
   always @(negedge bus_clk) begin
      #5;
      if (!finished) begin
         chk(rst_n ? "R2" : "R1", "wr_done", 32'(wr_done), 32'(m_done));
         chk(rst_n ? "R7" : "R1", "acc_err", 32'(acc_err), 32'(m_err));
         chk(rst_n ? "R4" : "R1", "slow_we", 32'(slow_we), 32'(slow_cnt == 1));
         chk("R5", "rd_ok", 32'(rd_ok), 32'(rd_en && (!in_win(addr) || m_done)));
         chk("R8", "byp_wr", 32'(byp_wr), 32'(wr_en && !in_win(addr)));
         chk("R3", "slow_addr", 32'(slow_addr), 32'(m_addr));
         chk("R3", "slow_wdata", 32'(slow_wdata), 32'(m_data));
      end
   end

   task automatic cyc(input bit w, input bit r, input int a, input int d);
      @(negedge bus_clk);
      wr_en = w; rd_en = r; addr = AW'(a); wdata = DW'(d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
   endtask

   task automatic wait_done();
      for (int i = 0; i < 200 && !m_done; i++) cyc(0, 0, 0, 0);
      cyc(0, 0, 0, 0);
   endtask

   task automatic do_reset();
      @(negedge bus_clk);
      rst_n = 1'b0; wr_en = 0; rd_en = 0;
      idle(3);
      rst_n = 1'b1;
   endtask

   initial begin
      #1 rst_n = 1'b0;
      idle(4);
      rst_n = 1'b1;                       // R1 reset values checked throughout
      idle(2);

      // R2 R3 R4: single accepted window write
      cyc(1, 0, 5, 8'hA5);
      wait_done();

      // R6 R7: early write right behind an accepted one
      cyc(1, 0, 4, 8'h3C);
      cyc(1, 0, 6, 8'hFF);
      cyc(0, 1, 7, 0);                    // R5 blocked read
      cyc(0, 1, 1, 0);                    // R8 bypass read
      cyc(1, 0, 0, 8'h11);                // R8 bypass write while busy
      cyc(1, 0, 3, 8'h22);                // R8 lower edge outside
      cyc(1, 0, 12, 8'h33);               // R8 upper edge outside
      wait_done();
      cyc(0, 1, 11, 0);                   // R5 allowed read
      idle(2);

      // R1: reset clears the sticky error
      do_reset();
      idle(2);

      // R2 R3: back-to-back polled writes, window edges included
      for (int k = 0; k < 8; k++) begin
         cyc(1, 0, LO + k, 8'h40 + 8'(k * 13));
         wait_done();
      end

      // R6: early write at the upper edge while a transfer is in flight
      cyc(1, 0, HI, 8'h5A);
      idle(2);
      cyc(1, 0, HI, 8'hC3);
      wait_done();
      // R8: bypass write while idle leaves wr_done high
      cyc(1, 0, 15, 8'h77);
      idle(3);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge bus_clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule